// File: doc/BRIEF.md
# Thread-Qualified Cascading Event Counter Pair

This block holds two event counters for a core that runs two hardware threads. Each counter sees its own stream of single-cycle event pulses. Every pulse carries three things: a flag that says whether it belongs to one thread or to neither, a source identifier, and the privilege level that each thread is running at in that cycle. Bit 0 of the identifier names the thread. A counter advances only when its four qualifier bits accept the pulse. The four bits enable user or kernel counting for thread 0 and for thread 1.

A counter can also be placed in cascade mode. In that mode it stays idle until the other counter of the pair wraps. From then on it counts normally until software clears its cascade bit or the block is reset. When a counter wraps past all ones it returns to zero and sets a sticky overflow flag in its control register. A shared output pulses for one cycle each time a flag is set. Software reaches the counts and the control registers through a simple write port and a combinational read port.

Top module: `tq_counter_pair`

## Requirements
- R1: After reset both counts read 0, both control registers read 0, and `ovf_pulse` is 0.
- R2: Register addresses are: 0 = count of counter 0, 1 = control of counter 0, 2 = count of counter 1, 3 = control of counter 1. A write is visible on `rd_data` from the next cycle. Counts are CNT_W (40) bits wide, and upper write bits are dropped. The control register holds bit 0 = thread 0 user enable, bit 1 = thread 0 kernel enable, bit 2 = thread 1 user enable, bit 3 = thread 1 kernel enable, bit 30 = cascade, and bit 31 = overflow. All other control bits read 0.
- R3: A thread-specific pulse (`ev_indep` = 0) from thread t counts only if thread t's enable matches thread t's privilege, taken from `thr_kern[t]` (1 = kernel, 0 = user). The other thread's enables have no effect.
- R4: A thread-independent pulse (`ev_indep` = 1) counts when any of these holds: thread 0 is in kernel with its kernel enable set, thread 0 is in user with its user enable set, thread 1 is in kernel with its kernel enable set, or thread 1 is in user with its user enable set.
- R5: The thread of a pulse is bit 0 of its ID_W-bit source identifier, and the higher bits are ignored.
- R6: With all four enables clear a counter never counts. With all four set it counts every pulse, whatever the thread or privilege.
- R7: A count at all ones that takes a counted pulse becomes 0 at the next edge, and control bit 31 becomes 1 at the same edge.
- R8: The overflow flag stays set through further counting. It changes only when software writes control bit 31.
- R9: `ovf_pulse` is high for exactly the one cycle after each wrap of either counter.
- R10: A counter with cascade set ignores pulses until its partner wraps. It then counts pulses from the cycle after that wrap onward, for as long as cascade stays set.
- R11: A write to either register of a counter in the same cycle as a pulse to that counter drops the pulse. The write's value is what remains.
- R12: Clearing the cascade bit makes the counter count on its own. Setting the bit again returns it to the idle state, where it waits for a new partner wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 2 | Event pulse per counter |
| ev_indep | input | 2 | Per counter: 1 = thread-independent pulse |
| ev_src_id | input | 2*ID_W | Source identifier per counter; counter i uses bits [i*ID_W +: ID_W] |
| thr_kern | input | 2 | Per thread privilege: 1 = kernel, 0 = user |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | DATA_W | Write data (DATA_W = max(CNT_W, 32)) |
| rd_addr | input | 2 | Read register address |
| rd_data | output | DATA_W | Read data, combinational |
| ovf_pulse | output | 1 | One-cycle pulse when an overflow flag is set |

## Verification
Some properties are checked on every cycle. These cover wraps that set the flag and zero the count, the flag staying sticky without a control write, a count that does not move without an accepted pulse, a cascaded counter that does not move while it waits, write priority over pulses, and every overflow pulse being backed by a set flag. Other behaviour needs the bench's scenarios to be seen. This covers the qualifier decode across thread, privilege and pulse kind, taking the thread from the identifier's low bit, and the arm, count, disarm and re-arm order of cascade mode. It also covers register readback and the exact one-cycle width of the overflow pulse.

// File: rtl/tqc_pkg.sv
package tqc_pkg;

    localparam int NUM_CTR  = 2;
    localparam int CTL_W    = 32;
    localparam int CASC_BIT = 30;
    localparam int OVF_BIT  = 31;
    localparam int QUAL_W   = 4;

    // bit 0 = thread 0 user, bit 1 = thread 0 kernel,
    // bit 2 = thread 1 user, bit 3 = thread 1 kernel
    typedef struct packed {
        logic t1_kern;
        logic t1_user;
        logic t0_kern;
        logic t0_user;
    } qual_t;

    typedef struct packed {
        logic  ovf;
        logic  cascade;
        qual_t qual;
    } ctl_t;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;

    function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.ovf     = w[OVF_BIT];
        c.cascade = w[CASC_BIT];
        c.qual    = qual_t'(w[QUAL_W-1:0]);
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
        logic [CTL_W-1:0] w;
        w                = '0;
        w[OVF_BIT]       = c.ovf;
        w[CASC_BIT]      = c.cascade;
        w[QUAL_W-1:0]    = c.qual;
        return w;
    endfunction

    // Privilege match for one thread: kernel enable when in kernel,
    // user enable otherwise.
    function automatic logic priv_match(input logic in_kern,
                                        input logic kern_en,
                                        input logic user_en);
        return in_kern ? kern_en : user_en;
    endfunction

endpackage

// File: rtl/tqc_qualifier.sv
module tqc_qualifier
    import tqc_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            ev_valid,
    input  logic            ev_indep,
    input  logic [ID_W-1:0] ev_src_id,
    input  logic [1:0]      thr_kern,
    input  qual_t           qual,
    output logic            hit
);

    logic tid;
    logic match_t0;
    logic match_t1;
    logic unused_id_hi;

    assign tid          = ev_src_id[0];
    assign unused_id_hi = ^ev_src_id[ID_W-1:1];

    assign match_t0 = priv_match(thr_kern[0], qual.t0_kern, qual.t0_user);
    assign match_t1 = priv_match(thr_kern[1], qual.t1_kern, qual.t1_user);

    always_comb begin
        if (!ev_valid) begin
            hit = 1'b0;
        end else if (ev_indep) begin
            hit = match_t0 | match_t1;
        end else begin
            hit = tid ? match_t1 : match_t0;
        end
    end

endmodule

// File: rtl/tqc_counter.sv
module tqc_counter
    import tqc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int DATA_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              partner_wrap,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_q,
    output ctl_t              ctl_q,
    output logic              wrap
);

    logic armed_q;
    logic gate_open;
    logic inc;
    logic casc_next;
    logic unused_wr;

    assign unused_wr = ^wr_data;

    assign gate_open = !ctl_q.cascade || armed_q;
    assign inc       = hit && gate_open && !wr_cnt && !wr_ctl;
    assign wrap      = inc && (&cnt_q);
    assign casc_next = wr_ctl ? wr_data[CASC_BIT] : ctl_q.cascade;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ctl_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_cnt) begin
                cnt_q <= wr_data[CNT_W-1:0];
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (wr_ctl) begin
                ctl_q <= ctl_unpack(wr_data[CTL_W-1:0]);
            end else if (wrap) begin
                ctl_q.ovf <= 1'b1;
            end

            armed_q <= casc_next && (armed_q || partner_wrap);
        end
    end

    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && gate_open && !wr_cnt && !wr_ctl && (&cnt_q))
        |=> (cnt_q == '0) && ctl_q.ovf);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ovf && !wr_ctl) |=> ctl_q.ovf);

    assert_no_hit_no_count_R3: assert property (@(posedge clk) disable iff (rst)
        (!hit && !wr_cnt) |=> $stable(cnt_q));

    assert_cascade_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cascade && !armed_q && !wr_cnt) |=> $stable(cnt_q));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

endmodule

// File: rtl/tq_counter_pair.sv
module tq_counter_pair
    import tqc_pkg::*;
#(
    parameter int  CNT_W  = 40,
    parameter int  ID_W   = 8,
    localparam int DATA_W = (CNT_W > CTL_W) ? CNT_W : CTL_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CTR-1:0]      ev_valid,
    input  logic [NUM_CTR-1:0]      ev_indep,
    input  logic [NUM_CTR*ID_W-1:0] ev_src_id,
    input  logic [1:0]              thr_kern,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [1:0]              rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    ovf_pulse
);

    logic [CNT_W-1:0]   cnt_q [NUM_CTR];
    ctl_t               ctl_q [NUM_CTR];
    logic [NUM_CTR-1:0] hit;
    logic [NUM_CTR-1:0] wrap;
    logic [NUM_CTR-1:0] flags;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic wr_hit;
        assign wr_hit   = wr_en && (wr_addr[1] == 1'(i));
        assign flags[i] = ctl_q[i].ovf;

        tqc_qualifier #(
            .ID_W (ID_W)
        ) u_qual (
            .ev_valid  (ev_valid[i]),
            .ev_indep  (ev_indep[i]),
            .ev_src_id (ev_src_id[i*ID_W +: ID_W]),
            .thr_kern  (thr_kern),
            .qual      (ctl_q[i].qual),
            .hit       (hit[i])
        );

        tqc_counter #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_ctr (
            .clk          (clk),
            .rst          (rst),
            .hit          (hit[i]),
            .partner_wrap (wrap[NUM_CTR-1-i]),
            .wr_cnt       (wr_hit && (reg_sel_e'(wr_addr[0]) == SEL_COUNT)),
            .wr_ctl       (wr_hit && (reg_sel_e'(wr_addr[0]) == SEL_CTRL)),
            .wr_data      (wr_data),
            .cnt_q        (cnt_q[i]),
            .ctl_q        (ctl_q[i]),
            .wrap         (wrap[i])
        );
    end

    always_comb begin
        if (reg_sel_e'(rd_addr[0]) == SEL_CTRL) begin
            rd_data = DATA_W'(ctl_pack(ctl_q[rd_addr[1]]));
        end else begin
            rd_data = DATA_W'(cnt_q[rd_addr[1]]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= |wrap;
        end
    end

    assert_pulse_backed_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (|flags));

    assert_pulse_follows_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> ovf_pulse);

endmodule

// File: tb/tq_counter_pair_bench.sv
module tq_counter_pair_bench;

    localparam int CNT_W  = 40;
    localparam int ID_W   = 8;
    localparam int DATA_W = 40;

    localparam logic [DATA_W-1:0] QU0  = 40'h1;
    localparam logic [DATA_W-1:0] QK0  = 40'h2;
    localparam logic [DATA_W-1:0] QU1  = 40'h4;
    localparam logic [DATA_W-1:0] QK1  = 40'h8;
    localparam logic [DATA_W-1:0] CASC = 40'h40000000;
    localparam logic [DATA_W-1:0] OVF  = 40'h80000000;
    localparam logic [DATA_W-1:0] MAXC = {CNT_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        ev_valid;
    logic [1:0]        ev_indep;
    logic [2*ID_W-1:0] ev_src_id;
    logic [1:0]        thr_kern;
    logic              wr_en;
    logic [1:0]        wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]        rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tq_counter_pair #(.CNT_W(CNT_W), .ID_W(ID_W)) u_tq_counter_pair (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_indep(ev_indep),
        .ev_src_id(ev_src_id), .thr_kern(thr_kern), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_pulse(ovf_pulse)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [1:0] a,
                             input logic [DATA_W-1:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one pulse per selected counter for one cycle
    task automatic fire(input logic [1:0] v, input logic [1:0] ind,
                        input logic [7:0] id0, input logic [7:0] id1);
        @(negedge clk);
        ev_valid = v; ev_indep = ind; ev_src_id = {id1, id0};
        @(negedge clk);
        ev_valid = 2'b00;
    endtask

    task automatic clear_all();
        reg_write(2'd0, '0); reg_write(2'd1, '0);
        reg_write(2'd2, '0); reg_write(2'd3, '0);
    endtask

    task automatic t_reset();
        check_reg("R1 cnt0", 2'd0, '0);
        check_reg("R1 ctl0", 2'd1, '0);
        check_reg("R1 cnt1", 2'd2, '0);
        check_reg("R1 ctl1", 2'd3, '0);
        check("R1 pulse", {39'd0, ovf_pulse}, '0);
    endtask

    task automatic t_regs();
        reg_write(2'd0, 40'h12_3456_789A);
        check_reg("R2 cnt0", 2'd0, 40'h12_3456_789A);
        reg_write(2'd3, 40'hFF_FFFF_FFFF);
        check_reg("R2 ctl1 mask", 2'd3, OVF | CASC | 40'hF);
        reg_write(2'd2, 40'h00_0000_0077);
        check_reg("R2 cnt1", 2'd2, 40'h77);
        clear_all();
    endtask

    task automatic t_thread_specific();
        thr_kern = 2'b00;
        reg_write(2'd1, QU1 | QK1);
        fire(2'b01, 2'b00, 8'h00, 8'h00);
        check_reg("R3 t1 enables ignore t0 pulse", 2'd0, 40'd0);
        reg_write(2'd1, QU0);
        fire(2'b01, 2'b00, 8'h00, 8'h00);
        check_reg("R3 t0 user counts", 2'd0, 40'd1);
        thr_kern = 2'b01;
        fire(2'b01, 2'b00, 8'h00, 8'h00);
        check_reg("R3 t0 kernel blocked", 2'd0, 40'd1);
        thr_kern = 2'b00;
        fire(2'b01, 2'b00, 8'h01, 8'h00);
        check_reg("R3 t1 pulse ignores t0 enable", 2'd0, 40'd1);
        clear_all();
    endtask

    task automatic t_thread_indep();
        reg_write(2'd1, QK1);
        thr_kern = 2'b00;
        fire(2'b01, 2'b01, 8'h00, 8'h00);
        check_reg("R4 no term true", 2'd0, 40'd0);
        thr_kern = 2'b10;
        fire(2'b01, 2'b01, 8'h00, 8'h00);
        check_reg("R4 t1 kernel term", 2'd0, 40'd1);
        reg_write(2'd1, QU0);
        thr_kern = 2'b10;
        fire(2'b01, 2'b01, 8'h01, 8'h00);
        check_reg("R4 t0 user term", 2'd0, 40'd2);
        clear_all();
    endtask

    task automatic t_thread_id();
        thr_kern = 2'b00;
        reg_write(2'd3, QU1);
        fire(2'b10, 2'b00, 8'h00, 8'h03);
        check_reg("R5 id 03 is thread 1", 2'd2, 40'd1);
        fire(2'b10, 2'b00, 8'h00, 8'h02);
        check_reg("R5 id 02 is thread 0", 2'd2, 40'd1);
        clear_all();
    endtask

    task automatic t_all_or_none();
        for (int k = 0; k < 8; k++) begin
            thr_kern = 2'(k);
            fire(2'b01, {1'b0, k[2]}, {7'd0, k[0]}, 8'h00);
        end
        check_reg("R6 all clear zero", 2'd0, 40'd0);
        reg_write(2'd1, QU0 | QK0 | QU1 | QK1);
        for (int k = 0; k < 8; k++) begin
            thr_kern = 2'(k);
            fire(2'b01, {1'b0, k[2]}, {7'd0, k[0]}, 8'h00);
        end
        check_reg("R6 all set counts all", 2'd0, 40'd8);
        clear_all();
    endtask

    task automatic t_wrap();
        reg_write(2'd3, QU0 | QK0 | QU1 | QK1);
        reg_write(2'd2, MAXC - 1);
        fire(2'b10, 2'b01, 8'h00, 8'h00);
        check_reg("R7 at max", 2'd2, MAXC);
        check("R9 no pulse before wrap", {39'd0, ovf_pulse}, '0);
        @(negedge clk);
        ev_valid = 2'b10; ev_indep = 2'b10;
        @(negedge clk);
        ev_valid = 2'b00;
        check("R9 pulse after wrap", {39'd0, ovf_pulse}, 40'd1);
        check_reg("R7 wrapped to zero", 2'd2, '0);
        check_reg("R7 flag set", 2'd3, OVF | 40'hF);
        @(negedge clk);
        check("R9 pulse one cycle", {39'd0, ovf_pulse}, '0);
        fire(2'b10, 2'b10, 8'h00, 8'h00);
        check_reg("R8 flag sticky", 2'd3, OVF | 40'hF);
        reg_write(2'd3, 40'hF);
        check_reg("R8 flag cleared by write", 2'd3, 40'hF);
        clear_all();
    endtask

    task automatic t_cascade();
        reg_write(2'd1, 40'hF);
        reg_write(2'd3, CASC | 40'hF);
        reg_write(2'd0, MAXC - 1);
        fire(2'b11, 2'b11, 8'h00, 8'h00);
        check_reg("R10 idle before partner wrap", 2'd2, 40'd0);
        fire(2'b11, 2'b11, 8'h00, 8'h00);
        check_reg("R10 idle in partner wrap cycle", 2'd2, 40'd0);
        fire(2'b11, 2'b11, 8'h00, 8'h00);
        check_reg("R10 counts after partner wrap", 2'd2, 40'd1);
        fire(2'b10, 2'b11, 8'h00, 8'h00);
        check_reg("R10 keeps counting", 2'd2, 40'd2);
        reg_write(2'd3, 40'hF);
        fire(2'b10, 2'b11, 8'h00, 8'h00);
        check_reg("R12 independent after clear", 2'd2, 40'd3);
        reg_write(2'd3, CASC | 40'hF);
        fire(2'b10, 2'b11, 8'h00, 8'h00);
        check_reg("R12 re-armed waits again", 2'd2, 40'd3);
        clear_all();
    endtask

    task automatic t_write_priority();
        reg_write(2'd1, 40'hF);
        @(negedge clk);
        ev_valid = 2'b01; ev_indep = 2'b01;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 40'd5;
        @(negedge clk);
        ev_valid = 2'b00; wr_en = 1'b0;
        check_reg("R11 count write wins", 2'd0, 40'd5);
        @(negedge clk);
        ev_valid = 2'b01; ev_indep = 2'b01;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 40'hF;
        @(negedge clk);
        ev_valid = 2'b00; wr_en = 1'b0;
        check_reg("R11 control write drops pulse", 2'd0, 40'd5);
        clear_all();
    endtask

    initial begin
        rst = 1'b1; ev_valid = '0; ev_indep = '0; ev_src_id = '0;
        thr_kern = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_thread_specific();
        t_thread_indep();
        t_thread_id();
        t_all_or_none();
        t_wrap();
        t_cascade();
        t_write_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule